// File: doc/BRIEF.md
# Reset Cause Status Tracker

This block keeps a byte of sticky flags that tell firmware why the processor last restarted or woke. It watches one-cycle event pulses for these sources: power-on, brown-out, external master-clear, the reset instruction, watchdog expiry, stack overflow and underflow, and interrupt wake-up. From the event that wins in a cycle, it works out which flags to set, clear or keep. It also decides whether the event is a real reset or only a resume from a low-power state. For a resume it computes the program-counter value at which execution continues.

A real reset raises `full_rst` and `pc_load` for one cycle with a zero load value. A wake-up from sleep or idle raises only `pc_load`, with the current PC advanced by two or with an interrupt vector. Firmware can overwrite the whole flag byte through a plain write strobe. All outputs are registered, so they appear in the cycle after the event pulse.

Top module: `rst_cause_tracker`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `status` is 00h and `full_rst` and `pc_load` are low. The `status` bit map is: bit0 brown-out, bit1 power-on, bit2 power-down, bit3 time-out, bit4 reset-instruction, bit5 software brown-out enable, bit6 stack-full, bit7 stack-underflow.
- R2: Every true reset raises `full_rst` and `pc_load` together for exactly the one cycle after the event, with `pc_val` equal to zero.
- R3: Power-on is a true reset. It sets bits 2, 3 and 4, clears bits 0, 1, 6 and 7, and sets bit5 only when `bor_cfg` is 2'b01.
- R4: Brown-out is a true reset. It sets bits 2, 3 and 4, clears bit0, and leaves bits 1, 6 and 7 unchanged. Bit5 keeps its value when `bor_cfg` is 2'b01 and is cleared otherwise. This same bit5 rule applies to every true reset other than power-on.
- R5: Master-clear is a true reset. In run mode (`in_lowpwr` low) bits 0-4 and 6-7 are unchanged. In low-power mode it sets bit3 and clears bit2.
- R6: A watchdog expiry in run mode is a true reset that clears bit3.
- R7: A watchdog expiry while `in_lowpwr` is high is not a reset. It clears bits 2 and 3 and pulses `pc_load` with `pc_val` = `cur_pc` + 2, taken modulo 2^PC_W.
- R8: A stack-full or stack-underflow event with `stk_rst_en` high is a true reset. It sets bit6 or bit7 respectively.
- R9: A stack-full or stack-underflow event with `stk_rst_en` low only sets bit6 or bit7 respectively. `full_rst` and `pc_load` stay low.
- R10: The reset instruction is a true reset that clears bit4.
- R11: An interrupt wake-up while `in_lowpwr` is high clears bit2 and pulses `pc_load` without `full_rst`. The load value is `VEC_HI` if `gie_hi` is high, else `VEC_LO` if `gie_lo` is high, else `cur_pc` + 2. When `in_lowpwr` is low, the interrupt wake-up has no effect.
- R12: When events coincide, only one is applied. Priority from highest to lowest: power-on, brown-out, master-clear, watchdog, stack-full, stack-underflow, reset instruction, interrupt wake-up.
- R13: `wr_en` loads `wr_data` into `status` in the next cycle. Any event in the same cycle takes precedence and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low clearing of the tracker registers |
| ev_por | input | 1 | Power-on event pulse |
| ev_bor | input | 1 | Brown-out event pulse |
| ev_mclr | input | 1 | External master-clear pulse |
| ev_rsti | input | 1 | Reset instruction executed |
| ev_wdt | input | 1 | Watchdog expiry pulse |
| ev_stk_full | input | 1 | Stack overflow detected |
| ev_stk_under | input | 1 | Stack underflow detected |
| ev_irq_wake | input | 1 | Interrupt wake-up request |
| in_lowpwr | input | 1 | Core is in sleep or idle |
| stk_rst_en | input | 1 | Stack errors cause a reset |
| gie_hi | input | 1 | High-priority global interrupt enable |
| gie_lo | input | 1 | Low-priority global interrupt enable |
| bor_cfg | input | 2 | Brown-out configuration field |
| cur_pc | input | PC_W | Current program counter |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write value |
| status | output | 8 | Sticky flag byte |
| pc_val | output | PC_W | Program counter load value |
| pc_load | output | 1 | Program counter load strobe |
| full_rst | output | 1 | True reset asserted |

## Verification
The bench builds the tracker with PC_W = 12 and keeps the default vector addresses. With that width, a sleep-mode watchdog wake taken at PC FFEh reaches the wrap of the PC + 2 sum, which returns 000h. The bench then tells this apart from a true reset only through `full_rst`. The narrow counter also keeps both interrupt vectors inside the address range, so the vector-selection and priority cases run at that width too.

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker #(
  parameter int PC_W   = 21,
  parameter int VEC_HI = 'h008,
  parameter int VEC_LO = 'h018,
  parameter int STEP   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_por,
  input  logic            ev_bor,
  input  logic            ev_mclr,
  input  logic            ev_rsti,
  input  logic            ev_wdt,
  input  logic            ev_stk_full,
  input  logic            ev_stk_under,
  input  logic            ev_irq_wake,
  input  logic            in_lowpwr,
  input  logic            stk_rst_en,
  input  logic            gie_hi,
  input  logic            gie_lo,
  input  logic [1:0]      bor_cfg,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      status,
  output logic [PC_W-1:0] pc_val,
  output logic            pc_load,
  output logic            full_rst
);
  localparam int F_BOR = 0, F_POR = 1, F_PD = 2, F_TO = 3;
  localparam int F_RI = 4, F_SB = 5, F_SF = 6, F_SU = 7;

  logic [7:0]      nxt;
  logic            rst_nxt, ld_nxt;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] pc_step;
  logic            sb_ok;

  assign pc_step = cur_pc + PC_W'(STEP);
  assign sb_ok   = (bor_cfg == 2'b01);

  always_comb begin
    nxt     = status;
    rst_nxt = 1'b0;
    ld_nxt  = 1'b0;
    pc_nxt  = pc_step;
    if (ev_por) begin
      rst_nxt    = 1'b1;
      nxt        = '0;
      nxt[F_PD]  = 1'b1;
      nxt[F_TO]  = 1'b1;
      nxt[F_RI]  = 1'b1;
      nxt[F_SB]  = sb_ok;
    end else if (ev_bor) begin
      rst_nxt    = 1'b1;
      nxt[F_PD]  = 1'b1;
      nxt[F_TO]  = 1'b1;
      nxt[F_RI]  = 1'b1;
      nxt[F_BOR] = 1'b0;
    end else if (ev_mclr) begin
      rst_nxt = 1'b1;
      if (in_lowpwr) begin
        nxt[F_TO] = 1'b1;
        nxt[F_PD] = 1'b0;
      end
    end else if (ev_wdt) begin
      nxt[F_TO] = 1'b0;
      if (in_lowpwr) begin
        nxt[F_PD] = 1'b0;
        ld_nxt    = 1'b1;
      end else begin
        rst_nxt = 1'b1;
      end
    end else if (ev_stk_full) begin
      nxt[F_SF] = 1'b1;
      rst_nxt   = stk_rst_en;
    end else if (ev_stk_under) begin
      nxt[F_SU] = 1'b1;
      rst_nxt   = stk_rst_en;
    end else if (ev_rsti) begin
      nxt[F_RI] = 1'b0;
      rst_nxt   = 1'b1;
    end else if (ev_irq_wake && in_lowpwr) begin
      nxt[F_PD] = 1'b0;
      ld_nxt    = 1'b1;
      if (gie_hi)      pc_nxt = PC_W'(VEC_HI);
      else if (gie_lo) pc_nxt = PC_W'(VEC_LO);
    end else if (wr_en) begin
      nxt = wr_data;
    end
    if (rst_nxt) begin
      ld_nxt = 1'b1;
      pc_nxt = '0;
      if (!ev_por) nxt[F_SB] = sb_ok & status[F_SB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      pc_val   <= '0;
      pc_load  <= 1'b0;
      full_rst <= 1'b0;
    end else begin
      status   <= nxt;
      pc_val   <= ld_nxt ? pc_nxt : '0;
      pc_load  <= ld_nxt;
      full_rst <= rst_nxt;
    end
  end
endmodule

// File: rtl/rst_cause_tracker_chk.sv
module rst_cause_tracker_chk #(
  parameter int PC_W = 21
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_por,
  input logic            ev_bor,
  input logic            ev_mclr,
  input logic            ev_rsti,
  input logic            ev_wdt,
  input logic            ev_stk_full,
  input logic            ev_stk_under,
  input logic            in_lowpwr,
  input logic            stk_rst_en,
  input logic [7:0]      status,
  input logic [PC_W-1:0] pc_val,
  input logic            pc_load,
  input logic            full_rst
);
  logic above_stk;
  assign above_stk = ev_por | ev_bor | ev_mclr | ev_wdt;

  AST_RST_LOADS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst |-> (pc_load && pc_val == '0)); // R2

  AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ev_por)) |-> (!status[1] && !status[0] && full_rst)); // R3

  AST_WAKE_NOT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ev_wdt && in_lowpwr && !ev_por && !ev_bor && !ev_mclr))
    |-> (!full_rst && pc_load && !status[2] && !status[3])); // R7

  AST_UNDER_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ev_stk_under && !stk_rst_en && !above_stk && !ev_stk_full))
    |-> (status[7] && !pc_load && !full_rst)); // R9

  AST_RSTI_CLEARS_RI: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ev_rsti && !above_stk && !ev_stk_full && !ev_stk_under))
    |-> (!status[4] && full_rst)); // R10
endmodule

bind rst_cause_tracker rst_cause_tracker_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor), .ev_mclr(ev_mclr),
  .ev_rsti(ev_rsti), .ev_wdt(ev_wdt), .ev_stk_full(ev_stk_full),
  .ev_stk_under(ev_stk_under), .in_lowpwr(in_lowpwr), .stk_rst_en(stk_rst_en),
  .status(status), .pc_val(pc_val), .pc_load(pc_load), .full_rst(full_rst)
);

// File: tb/test_rst_cause_tracker.sv
module test_rst_cause_tracker;
  localparam int CLK_P = 10;
  localparam int PW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_por = 0, ev_bor = 0, ev_mclr = 0, ev_rsti = 0, ev_wdt = 0;
  logic ev_stk_full = 0, ev_stk_under = 0, ev_irq_wake = 0;
  logic in_lowpwr = 0, stk_rst_en = 0, gie_hi = 0, gie_lo = 0;
  logic [1:0] bor_cfg = 2'b01;
  logic [PW-1:0] cur_pc = '0;
  logic wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;
  logic [PW-1:0] pc_val;
  logic pc_load, full_rst;
  int n_chk = 0, n_bad = 0;

  rst_cause_tracker #(.PC_W(PW)) i_rst_cause_tracker (
    .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor), .ev_mclr(ev_mclr),
    .ev_rsti(ev_rsti), .ev_wdt(ev_wdt), .ev_stk_full(ev_stk_full),
    .ev_stk_under(ev_stk_under), .ev_irq_wake(ev_irq_wake), .in_lowpwr(in_lowpwr),
    .stk_rst_en(stk_rst_en), .gie_hi(gie_hi), .gie_lo(gie_lo), .bor_cfg(bor_cfg),
    .cur_pc(cur_pc), .wr_en(wr_en), .wr_data(wr_data), .status(status),
    .pc_val(pc_val), .pc_load(pc_load), .full_rst(full_rst));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_ev();
    {ev_por, ev_bor, ev_mclr, ev_rsti, ev_wdt} = '0;
    {ev_stk_full, ev_stk_under, ev_irq_wake, wr_en} = '0;
  endtask

  task automatic put(input logic [7:0] v);
    wr_en = 1; wr_data = v; step(); clr_ev();
    chk("R13 write", status, v);
  endtask

  task automatic expect_out(input string req, input logic [7:0] st, input logic rs,
                            input logic ld, input logic [PW-1:0] pv);
    chk({req, " status"}, status, st);
    chk({req, " full_rst"}, full_rst, rs);
    chk({req, " pc_load"}, pc_load, ld);
    if (ld) chk({req, " pc_val"}, pc_val, pv);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    expect_out("R1 in reset", 8'h00, 0, 0, 0);
    rst_n = 1; step();
    expect_out("R1 after reset", 8'h00, 0, 0, 0);
  endtask

  task automatic t_por();
    ev_por = 1; step(); clr_ev();
    expect_out("R3 por", 8'h3C, 1, 1, 0);
    step();
    chk("R2 single cycle rst", full_rst, 0);
    chk("R2 single cycle load", pc_load, 0);
    bor_cfg = 2'b10; ev_por = 1; step(); clr_ev();
    expect_out("R3 por cfg10", 8'h1C, 1, 1, 0);
    bor_cfg = 2'b01;
  endtask

  task automatic t_bor();
    put(8'hFF);
    ev_bor = 1; step(); clr_ev();
    expect_out("R4 bor keep", 8'hFE, 1, 1, 0);
    put(8'hFF); bor_cfg = 2'b00;
    ev_bor = 1; step(); clr_ev();
    expect_out("R4 bor cfg00", 8'hDE, 1, 1, 0);
    bor_cfg = 2'b01;
  endtask

  task automatic t_mclr();
    put(8'hFF);
    ev_mclr = 1; step(); clr_ev();
    expect_out("R5 mclr run", 8'hFF, 1, 1, 0);
    in_lowpwr = 1; ev_mclr = 1; step(); clr_ev(); in_lowpwr = 0;
    expect_out("R5 mclr sleep", 8'hFB, 1, 1, 0);
  endtask

  task automatic t_wdt();
    put(8'hFF);
    ev_wdt = 1; step(); clr_ev();
    expect_out("R6 wdt run", 8'hF7, 1, 1, 0);
    put(8'hFF); in_lowpwr = 1; cur_pc = 12'h100;
    ev_wdt = 1; step(); clr_ev();
    expect_out("R7 wdt wake", 8'hF3, 0, 1, 12'h102);
    put(8'hFF); cur_pc = 12'hFFE;
    ev_wdt = 1; step(); clr_ev(); in_lowpwr = 0;
    expect_out("R7 wdt wake wrap", 8'hF3, 0, 1, 12'h000);
  endtask

  task automatic t_stack();
    put(8'h00); stk_rst_en = 1;
    ev_stk_full = 1; step(); clr_ev();
    expect_out("R8 full rst", 8'h40, 1, 1, 0);
    put(8'h00);
    ev_stk_under = 1; step(); clr_ev();
    expect_out("R8 under rst", 8'h80, 1, 1, 0);
    put(8'h00); stk_rst_en = 0;
    ev_stk_under = 1; step(); clr_ev();
    expect_out("R9 under flag", 8'h80, 0, 0, 0);
    put(8'h00);
    ev_stk_full = 1; step(); clr_ev();
    expect_out("R9 full flag", 8'h40, 0, 0, 0);
  endtask

  task automatic t_rsti();
    put(8'hFF);
    ev_rsti = 1; step(); clr_ev();
    expect_out("R10 rsti", 8'hEF, 1, 1, 0);
  endtask

  task automatic t_irq();
    put(8'hFF); in_lowpwr = 1; cur_pc = 12'h200;
    gie_hi = 1; gie_lo = 1; ev_irq_wake = 1; step(); clr_ev();
    expect_out("R11 irq hi", 8'hFB, 0, 1, 12'h008);
    gie_hi = 0; ev_irq_wake = 1; step(); clr_ev();
    expect_out("R11 irq lo", 8'hFB, 0, 1, 12'h018);
    gie_lo = 0; ev_irq_wake = 1; step(); clr_ev();
    expect_out("R11 irq step", 8'hFB, 0, 1, 12'h202);
    put(8'hFF); in_lowpwr = 0;
    ev_irq_wake = 1; step(); clr_ev();
    expect_out("R11 irq ignored", 8'hFF, 0, 0, 0);
  endtask

  task automatic t_prio();
    put(8'hFF);
    ev_por = 1; ev_bor = 1; ev_rsti = 1; step(); clr_ev();
    expect_out("R12 por wins", 8'h3C, 1, 1, 0);
    put(8'hFF);
    ev_mclr = 1; ev_rsti = 1; ev_wdt = 1; step(); clr_ev();
    expect_out("R12 mclr wins", 8'hFF, 1, 1, 0);
    put(8'h00);
    ev_stk_full = 1; ev_stk_under = 1; ev_rsti = 1; step(); clr_ev();
    expect_out("R12 stack wins", 8'h40, 0, 0, 0);
    put(8'hFF);
    wr_en = 1; wr_data = 8'h00; ev_wdt = 1; step(); clr_ev();
    expect_out("R13 event beats write", 8'hF7, 1, 1, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_por(); t_bor(); t_mclr(); t_wdt();
        t_stack(); t_rsti(); t_irq(); t_prio();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule